// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a clocked monostable pulse generator. It is built for one channel. When it sees a qualified trigger edge, it drives a pulse of a programmed number of clock cycles on `pulse_o`. The complement of that pulse appears on `pulse_n_o`. Two trigger pins exist, and each one qualifies the other:

- `arm_hi_i` triggers on a rising edge, but only while `arm_lo_i` is high.
- `arm_lo_i` triggers on a falling edge, but only while `arm_hi_i` is low.

Tying the unused pin to its enabling level gives a pure rising-edge trigger or a pure falling-edge trigger.

Every accepted trigger starts a hold-off window of `holdoff_len_i` cycles, during which new edges are discarded. A timing window follows it. With `rearm_en_i` high, a qualified edge in the timing window restarts the whole sequence and so lengthens the pulse. With `rearm_en_i` low, edges are discarded for as long as the pulse is high.

An active-low clear (`clear_n_i`) aborts a pulse that is running and blocks triggers. An internal power-up hold-off does the same for the first `POWERUP_CYCLES` clocks. The three asynchronous inputs each pass through a two-stage synchronizer, so the block responds three clock edges after a change on a pin.

Top module: `retrig_oneshot`

## Requirements
- R1: A rising edge on `arm_hi_i`, with `arm_lo_i` high, starts a pulse when the block is idle. `pulse_o` goes high at the third rising clock edge after the input change. A rising edge with `arm_lo_i` low starts nothing.
- R2: A falling edge on `arm_lo_i`, with `arm_hi_i` low, starts a pulse with the same latency as R1. A falling edge with `arm_hi_i` high starts nothing. A rising `arm_lo_i` and a falling `arm_hi_i` never trigger.
- R3: After an accepted trigger that is not followed by a retrigger, `pulse_o` stays high for exactly `pulse_len_i` clocks (`pulse_len_i` ≥ 1). This holds however long the trigger input stays asserted.
- R4: A qualified edge is discarded while it falls within the first `holdoff_len_i` clocks of a pulse. `holdoff_len_i` must be less than `pulse_len_i`.
- R5: When `rearm_en_i` is 1, a qualified edge after the hold-off window restarts the count. `pulse_o` then stays high until `pulse_len_i` clocks after that edge is accepted.
- R6: When `rearm_en_i` is 0, every edge is discarded while `pulse_o` is high.
- R7: From the third clock edge after `clear_n_i` goes low, and for as long as it stays low, `pulse_o` is 0 and `pulse_n_o` is 1. A running pulse is terminated, and edges arriving while clear is low are discarded.
- R8: Clear needs no recovery time. An edge that reaches the synchronizer output on the same clock as the clear release is accepted.
- R9: For the first `POWERUP_CYCLES` clocks after power-up, `pulse_o` is 0 and every trigger edge is discarded.
- R10: `pulse_n_o` is always the complement of `pulse_o`. `pulse_o` is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| arm_hi_i | input | 1 | Asynchronous trigger, rising-edge sensitive, qualifies falling edges on `arm_lo_i` when low |
| arm_lo_i | input | 1 | Asynchronous trigger, falling-edge sensitive, qualifies rising edges on `arm_hi_i` when high |
| clear_n_i | input | 1 | Asynchronous active-low clear |
| rearm_en_i | input | 1 | 1: retriggerable, 0: non-retriggerable; change only while idle |
| pulse_len_i | input | CNT_W | Pulse length in clocks; hold stable during a pulse |
| holdoff_len_i | input | CNT_W | Hold-off length in clocks; hold stable during a pulse |
| pulse_o | output | 1 | One-shot output, high during the pulse |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Two functions can fall in the same clock:

- **Clear release and a trigger edge.** The bench changes `clear_n_i` and `arm_hi_i` on the same falling clock edge, so both leave the synchronizers together. The pulse is expected to start at once (R8).
- **End of a pulse and a new edge.** In the clock where the count reaches `pulse_len_i`, a retrigger must restart the count. In non-retriggerable mode the pulse must end, and the edge must not start a fresh one.

A behavioural reference model uses queues for the synchronizers and integers for the count. The bench compares both outputs against this model on every clock and judges each such collision cycle by that comparison.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Timing phase of the one-shot
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // output low, waiting for an edge
        PH_HOLD = 2'd1,   // hold-off: edges discarded
        PH_TIME = 2'd2    // timing: edges may retrigger
    } phase_e;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES] = '{default: '0};

    always_ff @(posedge clk_i) begin
        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/os_edge.sv
module os_edge (
    input  logic clk_i,
    input  logic lvl_hi_i,
    input  logic lvl_lo_i,
    output logic hit_o
);

    typedef struct packed {
        logic hi;
        logic lo;
    } prev_t;

    prev_t prev_d;
    prev_t prev_q = '0;

    always_comb begin
        prev_d    = prev_q;
        prev_d.hi = lvl_hi_i;
        prev_d.lo = lvl_lo_i;
    end

    always_ff @(posedge clk_i) begin
        prev_q <= prev_d;
    end

    // rising edge on hi qualified by lo high, falling edge on lo qualified by hi low
    assign hit_o = (lvl_hi_i & ~prev_q.hi & lvl_lo_i) |
                   (~lvl_lo_i & prev_q.lo & ~lvl_hi_i);

endmodule

// File: rtl/os_powerup.sv
module os_powerup #(
    parameter int POWERUP_CYCLES = 8
) (
    input  logic clk_i,
    output logic busy_o
);

    localparam int PW = $clog2(POWERUP_CYCLES + 1);
    localparam logic [PW-1:0] LIMIT = PW'(POWERUP_CYCLES);

    logic [PW-1:0] cnt_d;
    logic [PW-1:0] cnt_q = '0;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q < LIMIT);

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             hit_i,
    input  logic             run_en_i,
    input  logic             rearm_en_i,
    input  logic [CNT_W-1:0] pulse_len_i,
    input  logic [CNT_W-1:0] holdoff_len_i,
    output logic             pulse_o
);

    typedef struct packed {
        phase_e           phase;
        logic             pulse;
        logic [CNT_W-1:0] elapsed;
    } tstate_t;

    localparam tstate_t IDLE_ST = '{phase: PH_IDLE, pulse: 1'b0, elapsed: '0};

    tstate_t st_d;
    tstate_t st_q = IDLE_ST;
    logic    accept;
    logic [CNT_W-1:0] next_elapsed;

    always_comb begin
        accept = hit_i && ((st_q.phase == PH_IDLE) ||
                           (st_q.phase == PH_TIME && rearm_en_i));
        next_elapsed = st_q.elapsed + 1'b1;
        st_d = st_q;
        if (!run_en_i) begin
            st_d = IDLE_ST;
        end else if (accept) begin
            st_d.pulse   = 1'b1;
            st_d.elapsed = {{(CNT_W-1){1'b0}}, 1'b1};
            st_d.phase   = (holdoff_len_i != '0) ? PH_HOLD : PH_TIME;
        end else if (st_q.pulse) begin
            if (st_q.elapsed == pulse_len_i) begin
                st_d = IDLE_ST;
            end else begin
                st_d.elapsed = next_elapsed;
                st_d.phase   = (next_elapsed <= holdoff_len_i) ? PH_HOLD : PH_TIME;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot #(
    parameter int CNT_W          = 8,
    parameter int SYNC_STAGES    = 2,
    parameter int POWERUP_CYCLES = 8
) (
    input  logic             clk_i,
    input  logic             arm_hi_i,
    input  logic             arm_lo_i,
    input  logic             clear_n_i,
    input  logic             rearm_en_i,
    input  logic [CNT_W-1:0] pulse_len_i,
    input  logic [CNT_W-1:0] holdoff_len_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] raw_in;
    logic [N_ASYNC-1:0] sync_in;
    logic               lvl_hi;
    logic               lvl_lo;
    logic               clear_sync;
    logic               hit;
    logic               pwr_busy;
    logic               run_en;
    logic               pulse;

    assign raw_in = {clear_n_i, arm_lo_i, arm_hi_i};

    os_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign lvl_hi     = sync_in[0];
    assign lvl_lo     = sync_in[1];
    assign clear_sync = sync_in[2];

    os_edge u_edge (
        .clk_i    (clk_i),
        .lvl_hi_i (lvl_hi),
        .lvl_lo_i (lvl_lo),
        .hit_o    (hit)
    );

    os_powerup #(.POWERUP_CYCLES(POWERUP_CYCLES)) u_pwr (
        .clk_i  (clk_i),
        .busy_o (pwr_busy)
    );

    assign run_en = clear_sync & ~pwr_busy;

    os_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i         (clk_i),
        .hit_i         (hit),
        .run_en_i      (run_en),
        .rearm_en_i    (rearm_en_i),
        .pulse_len_i   (pulse_len_i),
        .holdoff_len_i (holdoff_len_i),
        .pulse_o       (pulse)
    );

    assign pulse_o   = pulse;
    assign pulse_n_o = ~pulse;

endmodule

// File: rtl/os_checker.sv
module os_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             pwr_busy_i,
    input logic             clear_sync_i,
    input logic             hit_i,
    input logic             rearm_en_i,
    input logic [CNT_W-1:0] pulse_len_i,
    input logic             pulse_i
);

    int unsigned high_run_q = 0;

    always_ff @(posedge clk_i) begin
        high_run_q <= pulse_i ? high_run_q + 1 : 0;
    end

    // R9
    powerup_blocks_chk: assert property (@(posedge clk_i)
        pwr_busy_i |=> !pulse_i);

    // R7
    clear_forces_low_chk: assert property (@(posedge clk_i) disable iff (pwr_busy_i)
        !clear_sync_i |=> !pulse_i);

    // R1
    idle_edge_starts_chk: assert property (@(posedge clk_i) disable iff (pwr_busy_i)
        (hit_i && clear_sync_i && !pulse_i) |=> pulse_i);

    // R6
    nonretrig_width_chk: assert property (@(posedge clk_i) disable iff (pwr_busy_i)
        (pulse_i && !rearm_en_i) |-> (high_run_q < int'(pulse_len_i)));

endmodule

bind retrig_oneshot os_checker #(.CNT_W(CNT_W)) u_os_checker (
    .clk_i        (clk_i),
    .pwr_busy_i   (pwr_busy),
    .clear_sync_i (clear_sync),
    .hit_i        (hit),
    .rearm_en_i   (rearm_en_i),
    .pulse_len_i  (pulse_len_i),
    .pulse_i      (pulse)
);

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;

    localparam int CW  = 8;
    localparam int PWR = 8;

    logic          clk = 1'b0;
    logic          arm_hi = 1'b0;
    logic          arm_lo = 1'b1;
    logic          clear_n = 1'b1;
    logic          rearm = 1'b1;
    logic [CW-1:0] plen = 8'd10;
    logic [CW-1:0] hlen = 8'd3;
    logic          pulse;
    logic          pulse_n;

    always #4 clk = ~clk;   // 125 MHz

    retrig_oneshot #(.CNT_W(CW), .SYNC_STAGES(2), .POWERUP_CYCLES(PWR)) u_retrig_oneshot (
        .clk_i         (clk),
        .arm_hi_i      (arm_hi),
        .arm_lo_i      (arm_lo),
        .clear_n_i     (clear_n),
        .rearm_en_i    (rearm),
        .pulse_len_i   (plen),
        .holdoff_len_i (hlen),
        .pulse_o       (pulse),
        .pulse_n_o     (pulse_n)
    );

    // ---------------- behavioural reference model ----------------
    bit     qa[$] = {1'b0, 1'b0};
    bit     qb[$] = {1'b0, 1'b0};
    bit     qc[$] = {1'b0, 1'b0};
    bit     last_a = 1'b0;
    bit     last_b = 1'b0;
    int     clocks = 0;
    bit     m_pulse = 1'b0;
    int     m_elapsed = 0;

    always @(posedge clk) begin
        bit a_s, b_s, c_s, edge_seen;
        a_s = qa[1];
        b_s = qb[1];
        c_s = qc[1];
        edge_seen = (a_s && !last_a && b_s) || (!b_s && last_b && !a_s);
        if (!c_s || clocks < PWR) begin
            m_pulse = 1'b0;
            m_elapsed = 0;
        end else if (edge_seen && (!m_pulse || (rearm && m_elapsed > int'(hlen)))) begin
            m_pulse = 1'b1;
            m_elapsed = 1;
        end else if (m_pulse) begin
            if (m_elapsed == int'(plen)) begin
                m_pulse = 1'b0;
                m_elapsed = 0;
            end else begin
                m_elapsed++;
            end
        end
        last_a = a_s;
        last_b = b_s;
        qa.push_front(arm_hi); void'(qa.pop_back());
        qb.push_front(arm_lo); void'(qb.pop_back());
        qc.push_front(clear_n); void'(qc.pop_back());
        clocks++;
    end

    // ---------------- comparison ----------------
    int    n_vec = 0;
    int    n_bad = 0;
    string req = "R9";
    bit    finished = 1'b0;

    always @(negedge clk) begin
        if (!finished) begin
            n_vec++;
            if (pulse !== m_pulse) begin
                n_bad++;
                $display("FAIL %s pulse_o=%b expected=%b at clock %0d", req, pulse, m_pulse, clocks);
            end
            n_vec++;
            if (pulse_n !== ~m_pulse) begin
                n_bad++;
                $display("FAIL R10 pulse_n_o=%b expected=%b at clock %0d", pulse_n, ~m_pulse, clocks);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire_hi();   // rising edge on arm_hi, one clock wide high
        arm_hi = 1'b1; step(1); arm_hi = 1'b0; step(1);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        step(1);
        // R9: edges during power-up are discarded
        req = "R9";
        arm_hi = 1'b1; step(2); arm_hi = 1'b0; step(2); arm_hi = 1'b1; step(3);
        arm_hi = 1'b0; step(20);

        // R1: rising edge qualified by arm_lo high
        req = "R1";
        fire_hi(); step(16);

        // R2: falling edge on arm_lo with arm_hi low
        req = "R2";
        arm_lo = 1'b0; step(16);
        // R1 negative: arm_hi rises while arm_lo is low
        req = "R1";
        arm_hi = 1'b1; step(10);
        // R2 negative: arm_lo rises, then falls while arm_hi high
        req = "R2";
        arm_lo = 1'b1; step(4); arm_lo = 1'b0; step(10);
        arm_hi = 1'b0; step(4); arm_lo = 1'b1; step(6);

        // R3: long trigger hold does not stretch pulse
        req = "R3";
        arm_hi = 1'b1; step(30); arm_hi = 1'b0; step(6);

        // R4: retrigger inside hold-off is discarded
        req = "R4";
        fire_hi(); fire_hi(); step(16);

        // R5: retrigger after hold-off extends the pulse
        req = "R5";
        fire_hi(); step(5); fire_hi(); step(20);
        // R5: retrigger landing on the final pulse clock
        fire_hi(); step(8); arm_hi = 1'b1; step(1); arm_hi = 1'b0; step(20);

        // R6: non-retriggerable mode discards edges while high
        req = "R6";
        rearm = 1'b0; step(1);
        fire_hi(); step(5); fire_hi(); step(20);
        fire_hi(); step(8); arm_hi = 1'b1; step(1); arm_hi = 1'b0; step(20);
        rearm = 1'b1; step(2);

        // R7: clear aborts a running pulse and blocks edges
        req = "R7";
        fire_hi(); step(3); clear_n = 1'b0; step(2);
        fire_hi(); fire_hi(); step(6);

        // R8: clear release together with an edge
        req = "R8";
        arm_hi = 1'b0; step(2);
        clear_n = 1'b1; arm_hi = 1'b1; step(16); arm_hi = 1'b0; step(4);

        // R3/R4: different lengths, no hold-off
        req = "R3";
        plen = 8'd5; hlen = 8'd0; step(2);
        fire_hi(); step(10);
        req = "R4";
        fire_hi(); step(1); fire_hi(); step(12);
        req = "R3";
        plen = 8'd1; step(2);
        fire_hi(); step(6);

        finish_run();
    end

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog expired, actual=running expected=done");
        finish_run();
    end

endmodule